// File: doc/BRIEF.md
# Time-Multiplexed Resonator Additive Synthesizer

This block builds audio samples as the sum of many sinusoidal partials. Every partial is a second-order recursive oscillator with its poles on the unit circle: it needs no excitation once its two state words are loaded. The value of k sets the partial's frequency. The two initial state words set its amplitude and phase. For a partial of amplitude A, phase φ and angular step ω, load k = 2cos(ω), the most recent state A·sin(φ−ω) and the older state A·sin(φ−2ω). One shared multiply-and-accumulate datapath serves the partials in turn, one partial per clock. Each partial's coefficient, state and channel assignment sit in internal register arrays.

A sample strobe starts a sweep. At the end of the sweep the block holds a left sum and a right sum. It then adds the per-channel sums from an upstream stage, so that several stages can be chained to add up their partial counts. It presents the raw sums together with rounded, saturated 20-bit samples. Host writes go to a shadow copy and take effect at the next strobe, so a sample never mixes old and new settings.

Both stream edges use valid/ready. The cascade input is accepted only while `up_ready` is high, which happens after the sweep ends. Data on the cascade input must stay stable until the transfer is accepted. A first stage in a chain ties `up_valid` high and feeds zeros. The output stays valid with stable data until `out_ready` is seen high. A new strobe aborts any sweep, join or pending output.

Top module: `res_synth`

## Requirements
- R1: Each sweep updates every partial once. The new value is y = trunc24(floor(k·y1 / 2^21)) − y2, wrapped to 24-bit two's complement. Then y2 takes the old y1 and y1 takes y. k is 24-bit signed with 21 fraction bits, so its range is [−4, 4).
- R2: The host port writes one field of partial `wr_idx` per cycle. `wr_sel` picks the field: 0 is k, 1 is y1 (the most recent state), 2 is y2 (the older state) and 3 is the channel, taken from `wr_data` bit 0 (0 for left, 1 for right).
- R3: A host write is not used by the datapath until the next strobe after the write. A write in the same cycle as a strobe waits for the strobe after that one. Fields that were not written keep their running values.
- R4: A strobe clears both sums and restarts the sweep at partial 0, dropping any pending output. `up_ready` goes high after the NPART+1th rising edge, counting the strobe edge as the first.
- R5: A partial's new value is added only to the sum of its own channel. The other channel's sum is unaffected.
- R6: `up_ready` stays high until `up_valid` is seen. On that transfer the upstream left and right sums are added to the local ones, and `out_valid` rises on the same edge.
- R7: `out_valid` holds, with `sum_*` and `smp_*` stable, until an edge where `out_ready` is high. `out_valid` is low after that edge.
- R8: `smp_*` is the sum plus 8, shifted right arithmetically by 4. This rounds to nearest, with ties rounded toward +∞.
- R9: A rounded value above 524287 is output as 524287. A rounded value below −524288 is output as −524288.
- R10: After reset every partial has k, y1 and y2 equal to zero and is on the left channel. The block is idle with `up_ready` and `out_valid` low. A sweep with no writes gives sums equal to the upstream inputs.
- R11: A partial loaded with k = 0, y1 = A, y2 = 0 yields the sequence 0, −A, 0, A, repeating every four samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| tick | input | 1 | sample strobe |
| wr_en | input | 1 | host write enable |
| wr_idx | input | IW | partial index for the write |
| wr_sel | input | 2 | field select (see R2) |
| wr_data | input | W | write data |
| up_valid | input | 1 | cascade input valid |
| up_ready | output | 1 | cascade input ready |
| up_l | input | AW | upstream left sum |
| up_r | input | AW | upstream right sum |
| out_valid | output | 1 | result valid |
| out_ready | input | 1 | result accepted |
| sum_l | output | AW | raw left sum for the next stage |
| sum_r | output | AW | raw right sum for the next stage |
| smp_l | output | OW | rounded, saturated left sample |
| smp_r | output | OW | rounded, saturated right sample |

## Verification
A wrong coefficient or state word in one partial shows up in the first sum after the strobe that commits it. Because the recurrence feeds back, the error then persists and grows in every later sample of that channel. A write that takes effect too early changes the sum of the very sample during which it was made. A misrouted channel shows up at once as a nonzero contribution on the other sum. Sequencing faults show as a shifted `up_ready` edge, or as output data changing while `out_valid` is held.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int DEF_W     = 24;
  localparam int DEF_OW    = 20;
  localparam int DEF_KFRAC = 21;

  typedef enum logic [1:0] {
    SEL_K  = 2'd0,
    SEL_Y1 = 2'd1,
    SEL_Y2 = 2'd2,
    SEL_CH = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_JOIN = 2'd2,
    ST_OUT  = 2'd3
  } st_e;
endpackage

// File: rtl/rs_bank.sv
module rs_bank #(
  parameter int NP = 64,
  parameter int W  = 24,
  parameter int IW = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  input  logic         upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [W-1:0] upd_y,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0] rd_k,
  output logic [W-1:0] rd_y1,
  output logic [W-1:0] rd_y2,
  output logic         rd_ch
);
  import rs_pkg::*;

  logic [W-1:0] k_q  [NP];
  logic [W-1:0] y1_q [NP];
  logic [W-1:0] y2_q [NP];
  logic         ch_q [NP];
  logic [W-1:0] sk_q  [NP];
  logic [W-1:0] sy1_q [NP];
  logic [W-1:0] sy2_q [NP];
  logic         sch_q [NP];
  logic [3:0]   dirty_q [NP];

  assign rd_k  = k_q[rd_idx];
  assign rd_y1 = y1_q[rd_idx];
  assign rd_y2 = y2_q[rd_idx];
  assign rd_ch = ch_q[rd_idx];

  for (genvar g = 0; g < NP; g++) begin : g_ent
    logic       hit;
    logic [3:0] wr_mask;
    logic       step;
    assign hit     = wr_en && (wr_idx == IW'(g));
    assign wr_mask = hit ? (4'b0001 << wr_sel) : 4'b0000;
    assign step    = upd_en && (upd_idx == IW'(g));

    // shadow copy written by the host
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sk_q[g]  <= '0;
        sy1_q[g] <= '0;
        sy2_q[g] <= '0;
        sch_q[g] <= 1'b0;
      end else if (hit) begin
        case (wsel_e'(wr_sel))
          SEL_K:   sk_q[g]  <= wr_data;
          SEL_Y1:  sy1_q[g] <= wr_data;
          SEL_Y2:  sy2_q[g] <= wr_data;
          default: sch_q[g] <= wr_data[0];
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) dirty_q[g] <= 4'b0000;
      else        dirty_q[g] <= (commit ? 4'b0000 : dirty_q[g]) | wr_mask;
    end

    // live copy used by the datapath
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        k_q[g]  <= '0;
        y1_q[g] <= '0;
        y2_q[g] <= '0;
        ch_q[g] <= 1'b0;
      end else if (commit) begin
        if (dirty_q[g][SEL_K])  k_q[g]  <= sk_q[g];
        if (dirty_q[g][SEL_Y1]) y1_q[g] <= sy1_q[g];
        if (dirty_q[g][SEL_Y2]) y2_q[g] <= sy2_q[g];
        if (dirty_q[g][SEL_CH]) ch_q[g] <= sch_q[g];
      end else if (step) begin
        y2_q[g] <= y1_q[g];
        y1_q[g] <= upd_y;
      end
    end

    AST_K_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(k_q[g]) && $stable(ch_q[g])); // R3
  end
endmodule

// File: rtl/rs_step.sv
module rs_step #(
  parameter int W     = 24,
  parameter int KFRAC = 21
) (
  input  logic [W-1:0] k,
  input  logic [W-1:0] y1,
  input  logic [W-1:0] y2,
  output logic [W-1:0] y_new
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;

  always_comb begin
    prod   = $signed(k) * $signed(y1);
    scaled = prod >>> KFRAC;
    y_new  = scaled[W-1:0] - y2;
  end
endmodule

// File: rtl/rs_acc.sv
module rs_acc #(
  parameter int W  = 24,
  parameter int AW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic          add_ch,
  input  logic [W-1:0]  add_val,
  input  logic          join_en,
  input  logic [AW-1:0] up_l,
  input  logic [AW-1:0] up_r,
  output logic [AW-1:0] acc_l,
  output logic [AW-1:0] acc_r
);
  localparam int EXT = AW - W;

  logic [AW-1:0] val_x;
  assign val_x = {{EXT{add_val[W-1]}}, add_val};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_l <= '0;
      acc_r <= '0;
    end else if (add_en) begin
      if (add_ch) acc_r <= acc_r + val_x;
      else        acc_l <= acc_l + val_x;
    end else if (join_en) begin
      acc_l <= acc_l + up_l;
      acc_r <= acc_r + up_r;
    end
  end

  AST_LEFT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    add_en && !add_ch && !clr |=> $stable(acc_r)); // R5
  AST_RIGHT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    add_en && add_ch && !clr |=> $stable(acc_l)); // R5
endmodule

// File: rtl/rs_round.sv
module rs_round #(
  parameter int AW = 31,
  parameter int W  = 24,
  parameter int OW = 20
) (
  input  logic [AW-1:0] acc,
  output logic [OW-1:0] smp
);
  localparam int SH   = W - OW;
  localparam int HI_I = 2 ** (OW - 1) - 1;
  localparam int LO_I = -(2 ** (OW - 1));
  localparam logic signed [AW:0] HALF = (AW + 1)'(2 ** (SH - 1));
  localparam logic signed [AW:0] HI   = (AW + 1)'(HI_I);
  localparam logic signed [AW:0] LO   = (AW + 1)'(LO_I);

  logic signed [AW:0] biased;
  logic signed [AW:0] shifted;

  always_comb begin
    biased  = $signed({acc[AW-1], acc}) + HALF;
    shifted = biased >>> SH;
    if (shifted > HI)      smp = HI[OW-1:0];
    else if (shifted < LO) smp = LO[OW-1:0];
    else                   smp = shifted[OW-1:0];
  end
endmodule

// File: rtl/res_synth.sv
module res_synth #(
  parameter  int NPART = 64,
  parameter  int W     = rs_pkg::DEF_W,
  parameter  int OW    = rs_pkg::DEF_OW,
  parameter  int KFRAC = rs_pkg::DEF_KFRAC,
  localparam int IW    = (NPART > 1) ? $clog2(NPART) : 1,
  localparam int AW    = W + IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_sel,
  input  logic [W-1:0]  wr_data,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [AW-1:0] up_l,
  input  logic [AW-1:0] up_r,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] sum_l,
  output logic [AW-1:0] sum_r,
  output logic [OW-1:0] smp_l,
  output logic [OW-1:0] smp_r
);
  import rs_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(NPART - 1);

  st_e           st_q;
  logic [IW-1:0] idx_q;
  logic          run;
  logic [W-1:0]  cur_k, cur_y1, cur_y2, y_next;
  logic          cur_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (tick) begin
      st_q  <= ST_RUN;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (idx_q == LAST) st_q <= ST_JOIN;
          else               idx_q <= idx_q + IW'(1);
        end
        ST_JOIN: if (up_valid)  st_q <= ST_OUT;
        ST_OUT:  if (out_ready) st_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  assign run       = (st_q == ST_RUN) && !tick;
  assign up_ready  = (st_q == ST_JOIN);
  assign out_valid = (st_q == ST_OUT);

  rs_bank #(.NP(NPART), .W(W), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
    .commit(tick), .upd_en(run), .upd_idx(idx_q), .upd_y(y_next),
    .rd_idx(idx_q), .rd_k(cur_k), .rd_y1(cur_y1), .rd_y2(cur_y2), .rd_ch(cur_ch)
  );

  rs_step #(.W(W), .KFRAC(KFRAC)) u_step (
    .k(cur_k), .y1(cur_y1), .y2(cur_y2), .y_new(y_next)
  );

  rs_acc #(.W(W), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(tick),
    .add_en(run), .add_ch(cur_ch), .add_val(y_next),
    .join_en(up_ready && up_valid && !tick),
    .up_l(up_l), .up_r(up_r), .acc_l(sum_l), .acc_r(sum_r)
  );

  rs_round #(.AW(AW), .W(W), .OW(OW)) u_rnd_l (.acc(sum_l), .smp(smp_l));
  rs_round #(.AW(AW), .W(W), .OW(OW)) u_rnd_r (.acc(sum_r), .smp(smp_r));

  AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !out_valid && !up_ready); // R4
  AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ready) |-> $past(st_q == ST_RUN && idx_q == LAST)); // R4
  AST_JOIN_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(up_valid && up_ready)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !tick |=> out_valid && $stable(sum_l) && $stable(sum_r)
      && $stable(smp_l) && $stable(smp_r)); // R7
endmodule

// File: tb/res_synth_test.sv
module res_synth_test;
  localparam int NP = 8;
  localparam int W  = 24;
  localparam int OW = 20;
  localparam int IW = 3;
  localparam int AW = W + IW + 1;
  localparam int ONE = 2097152;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [1:0] wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic up_valid = 1'b0, out_ready = 1'b0;
  logic up_ready, out_valid;
  logic [AW-1:0] up_l = '0, up_r = '0, sum_l, sum_r;
  logic [OW-1:0] smp_l, smp_r;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  res_synth #(.NPART(NP)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
    .up_valid(up_valid), .up_ready(up_ready), .up_l(up_l), .up_r(up_r),
    .out_valid(out_valid), .out_ready(out_ready),
    .sum_l(sum_l), .sum_r(sum_r), .smp_l(smp_l), .smp_r(smp_r)
  );

  // reference model: live and pending copies
  logic signed [W-1:0] mk[NP], my1[NP], my2[NP], pk[NP], py1[NP], py2[NP];
  logic mch[NP], pch[NP];
  logic [3:0] mdirty[NP];

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [W-1:0] step(logic signed [W-1:0] k, y1, y2);
    longint p = longint'(k) * longint'(y1);
    longint q = p >>> 21;
    logic [W-1:0] t = q[W-1:0] - y2;
    return t;
  endfunction

  function automatic longint rnd(longint s);
    longint t = (s + 8) >>> 4;
    if (t > 524287) t = 524287;
    if (t < -524288) t = -524288;
    return t;
  endfunction

  task automatic model_write(int idx, int sel, longint d);
    case (sel)
      0: pk[idx] = d[W-1:0];
      1: py1[idx] = d[W-1:0];
      2: py2[idx] = d[W-1:0];
      default: pch[idx] = d[0];
    endcase
    mdirty[idx][sel] = 1'b1;
  endtask

  task automatic model_commit();
    for (int i = 0; i < NP; i++) begin
      if (mdirty[i][0]) mk[i] = pk[i];
      if (mdirty[i][1]) my1[i] = py1[i];
      if (mdirty[i][2]) my2[i] = py2[i];
      if (mdirty[i][3]) mch[i] = pch[i];
      mdirty[i] = 4'b0;
    end
  endtask

  task automatic model_advance(output longint el, output longint er);
    el = 0; er = 0;
    for (int i = 0; i < NP; i++) begin
      logic signed [W-1:0] y = step(mk[i], my1[i], my2[i]);
      my2[i] = my1[i];
      my1[i] = y;
      if (mch[i]) er += longint'(y);
      else        el += longint'(y);
    end
  endtask

  task automatic host_write(int idx, int sel, longint d);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_sel = 2'(sel); wr_data = d[W-1:0];
    model_write(idx, sel, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one full sample; called at a negedge
  task automatic do_sample(longint ul, longint ur, int ud, int rd,
                           bit tw, int tw_idx, int tw_sel, longint tw_d,
                           bit mw, int mw_idx, int mw_sel, longint mw_d,
                           output longint gl, output longint gr);
    longint el, er;
    int cnt;
    tick = 1'b1;
    model_commit();
    if (tw) begin
      wr_en = 1'b1; wr_idx = IW'(tw_idx); wr_sel = 2'(tw_sel); wr_data = tw_d[W-1:0];
      model_write(tw_idx, tw_sel, tw_d);
    end
    model_advance(el, er);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; cnt = 1;
    if (mw) begin
      wr_en = 1'b1; wr_idx = IW'(mw_idx); wr_sel = 2'(mw_sel); wr_data = mw_d[W-1:0];
      model_write(mw_idx, mw_sel, mw_d);
      @(negedge clk);
      wr_en = 1'b0; cnt = 2;
    end
    while (!up_ready && cnt < 4 * NP) begin
      @(negedge clk);
      cnt++;
    end
    chk("R4 sweep length", cnt, NP + 1);
    up_l = ul[AW-1:0]; up_r = ur[AW-1:0];
    for (int i = 0; i < ud; i++) begin
      @(negedge clk);
      chk("R6 waiting ready", up_ready, 1);
      chk("R6 no early valid", out_valid, 0);
    end
    up_valid = 1'b1;
    @(negedge clk);
    up_valid = 1'b0;
    el += ul; er += ur;
    chk("R6 out_valid after join", out_valid, 1);
    chk("R5 R6 sum_l", longint'($signed(sum_l)), el);
    chk("R5 R6 sum_r", longint'($signed(sum_r)), er);
    chk("R8 R9 smp_l", longint'($signed(smp_l)), rnd(el));
    chk("R8 R9 smp_r", longint'($signed(smp_r)), rnd(er));
    gl = longint'($signed(smp_l)); gr = longint'($signed(smp_r));
    for (int i = 0; i < rd; i++) begin
      @(negedge clk);
      chk("R7 held valid", out_valid, 1);
      chk("R7 held smp_l", longint'($signed(smp_l)), rnd(el));
      chk("R7 held sum_r", longint'($signed(sum_r)), er);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7 valid drops after accept", out_valid, 0);
    gl = longint'($signed(sum_l)); gr = longint'($signed(sum_r));
  endtask

  typedef struct packed {
    logic signed [31:0] ul, ur;
    logic [7:0] ud, rd;
    logic signed [31:0] el, er;
  } vec_t;

  // all partials silent: samples are the rounded upstream sums (R8 R9 R10)
  localparam vec_t TBL[7] = '{
    '{32'sd0,       32'sd0,        8'd0, 8'd0, 32'sd0,      32'sd0},
    '{32'sd24,      32'sd23,       8'd0, 8'd0, 32'sd2,      32'sd1},
    '{-32'sd8,      -32'sd9,       8'd1, 8'd2, 32'sd0,      -32'sd1},
    '{32'sd7,       -32'sd7,       8'd0, 8'd1, 32'sd0,      32'sd0},
    '{32'sd8,       -32'sd24,      8'd2, 8'd0, 32'sd1,      -32'sd1},
    '{32'sd8388600, -32'sd8388616, 8'd0, 8'd0, 32'sd524287, -32'sd524288},
    '{32'sd8388599, -32'sd8388617, 8'd0, 8'd0, 32'sd524287, -32'sd524288}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint gl, gr;
    for (int i = 0; i < NP; i++) begin
      mk[i] = '0; my1[i] = '0; my2[i] = '0; mch[i] = 1'b0;
      pk[i] = '0; py1[i] = '0; py2[i] = '0; pch[i] = 1'b0; mdirty[i] = 4'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle up_ready", up_ready, 0);
    chk("R10 idle out_valid", out_valid, 0);

    foreach (TBL[v]) begin
      do_sample(TBL[v].ul, TBL[v].ur, int'(TBL[v].ud), int'(TBL[v].rd),
                0, 0, 0, 0, 0, 0, 0, 0, gl, gr);
      chk("R8 table smp_l", gl == TBL[v].ul ? 1 : 0, 1);
    end

    // strobe while output pending drops it (R4)
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    while (!up_ready) @(negedge clk);
    up_valid = 1'b1; @(negedge clk); up_valid = 1'b0;
    chk("R4 pending before strobe", out_valid, 1);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R4 strobe drops output", out_valid, 0);
    chk("R4 strobe drops ready", up_ready, 0);
    model_commit();
    model_advance(gl, gr);
    repeat (NP + 2) @(negedge clk);

    // load a mix of partials (R1 R2)
    host_write(0, 0, 0);        host_write(0, 1, 1000000);  host_write(0, 2, 0);
    host_write(1, 0, -ONE);     host_write(1, 1, 500000);   host_write(1, 3, 1);
    host_write(2, 0, 2965821);  host_write(2, 1, 2000000);
    host_write(3, 0, ONE);      host_write(3, 1, -700000);  host_write(3, 2, 300000);
    host_write(3, 3, 1);
    host_write(4, 0, 3900000);  host_write(4, 1, 100000);   host_write(4, 2, 90000);
    for (int s = 0; s < 3; s++)
      do_sample(s, -s, s % 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, gl, gr); // R1
    // mid-sweep write must wait (R3)
    do_sample(0, 0, 0, 0, 0, 0, 0, 0, 1, 4, 1, 123456, gl, gr);
    do_sample(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, gl, gr);
    // write in the strobe cycle waits one more strobe (R3)
    do_sample(0, 0, 0, 0, 1, 2, 2, -50000, 0, 0, 0, 0, gl, gr);
    do_sample(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, gl, gr);
    do_sample(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, gl, gr);

    // saturation with all partials on the left at full scale (R9)
    for (int i = 0; i < NP; i++) begin
      host_write(i, 0, 0); host_write(i, 1, 0); host_write(i, 2, -8388607);
      host_write(i, 3, 0);
    end
    do_sample(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, gl, gr);
    chk("R9 positive clamp", longint'($signed(smp_l)), 524287);
    do_sample(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, gl, gr);
    do_sample(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, gl, gr);
    chk("R9 negative clamp", longint'($signed(smp_l)), -524288);

    // single partial, k = 0: period of four on the right only (R11 R5)
    for (int i = 0; i < NP; i++) begin
      host_write(i, 1, 0); host_write(i, 2, 0);
    end
    host_write(5, 1, 1000); host_write(5, 3, 1);
    for (int s = 0; s < 8; s++) begin
      longint exp_r;
      do_sample(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, gl, gr);
      exp_r = (s % 4 == 1) ? -1000 : (s % 4 == 3) ? 1000 : 0;
      chk("R11 zero-crossing sequence", gr, exp_r);
      chk("R5 left untouched", gl, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule